// File: doc/BRIEF.md
# Power-On Configuration Init Sequencer

This block steers a configurable device from the moment its supply is valid up to the point where the configuration mode is known. While a power-on timer runs, or while a reprogram request is held, it clears the configuration frames. It emits one frame address with a clear strobe each cycle and repeats full passes over the frame range. The timer and the request are examined only when a pass reaches its last frame. Once both are idle, exactly one more pass is run, and then the block stops pulling the open-drain INIT line low.

After release the block watches the INIT pin level. Another device may keep the wire low, so the block waits until it actually reads the pin High. A master device, selected by a Low M0 strap, pauses for an extra programmable interval at that point and uses a power-on timer four times as long as a slave. The three mode pins are captured on the second clock after the one that sees INIT High or ends the master pause, and `ready` is raised. A reprogram request in any later phase sends the block back to frame clearing. The status levels for the low-data, high-data and done pins hold their power-up values for the whole phase this block covers.

Top module: `cfg_init_seq`

## Requirements
- R1: While `pwrOk` is Low, `initDriveLow` is 1, `clrStrobe` is 0 and `ready` is 0.
- R2: `ldcLevel` is 0, `doneLevel` is 0 and `hdcLevel` is 1 at all times.
- R3: In the clearing phase `clrStrobe` is 1 every cycle. `clrAddr` starts at 0 after power-up and steps by one, wrapping from NUM_FRAMES-1 to 0.
- R4: With `m0In` High (slave), the timer is busy for the first SLAVE_DELAY cycles after `pwrOk` rises and is tested only at the last frame of a pass. The number of strobes before INIT is released is (ceil((SLAVE_DELAY+1)/NUM_FRAMES)+1)*NUM_FRAMES.
- R5: With `m0In` Low (master), the timer length is 4*SLAVE_DELAY and the same strobe formula applies.
- R6: `progReq` (active High) held during clearing keeps passes running. After it drops, the pass in progress is finished and exactly one more pass follows: ceil(H/NUM_FRAMES)*NUM_FRAMES+NUM_FRAMES strobes for a request held H clearing cycles.
- R7: `initDriveLow` goes to 0 only after the final pass and stays 0 until a new request.
- R8: While the INIT pin reads Low after release, `ready` stays 0 and `modeOut` is not updated.
- R9: For a slave, `modePins` is latched into `modeOut` and `ready` rises on the second clock edge after the edge that first sees INIT High. This is three edges in all.
- R10: For a master, MASTER_WAIT extra cycles pass between seeing INIT High and the two-clock sampling step. Latency is MASTER_WAIT+3 edges.
- R11: `progReq` High outside clearing sends the block to clearing on the next edge: `ready` 0, `initDriveLow` 1, `clrAddr` 0.
- R12: While `ready` is 1, changes on `modePins` do not alter `modeOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| pwrOk | input | 1 | Supply valid; Low holds the block in its power-up state |
| progReq | input | 1 | Reprogram request, active High |
| initPinIn | input | 1 | Level read back from the INIT wire |
| m0In | input | 1 | Mode strap; Low selects master |
| modePins | input | 3 | Mode lines to be latched |
| clrAddr | output | AW | Frame address being cleared |
| clrStrobe | output | 1 | Frame clear strobe |
| initDriveLow | output | 1 | 1 pulls the open-drain INIT wire Low |
| ldcLevel | output | 1 | Low-data status level |
| hdcLevel | output | 1 | High-data status level |
| doneLevel | output | 1 | Done status level |
| modeOut | output | 3 | Latched mode lines |
| ready | output | 1 | Mode captured, loading may begin |

## Verification
Clearing is exercised with a slave strap and with a master strap, so the strobe totals separate the 1x and 4x timer lengths. A request held for a length that is not a multiple of the frame count shows that the request is only tested at pass boundaries and that one extra pass follows. The release is tried twice: once with INIT free, and once with it held Low by an outside agent, which shows that sampling waits for the real pin level. Changing the mode pins one clock after release pins down the exact latch edge, and the master run adds the extra pause.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;
  typedef enum logic [2:0] {
    ST_CLEAR, ST_FINAL, ST_WAIT_INIT, ST_MDELAY, ST_SYNC1, ST_SYNC2, ST_READY
  } seqState_t;

  typedef struct packed {
    logic clrRun;    // emit strobe and advance frame address
    logic addrZero;  // force frame address back to 0
    logic waitRun;   // master pause counter enable
    logic modeLoad;  // capture the mode lines
  } seqCtl_t;
endpackage

// File: rtl/cfgseq_dp.sv
module cfgseq_dp
  import cfgseq_pkg::*;
#(
  parameter int NUM_FRAMES  = 256,
  parameter int SLAVE_DELAY = 1600000,
  parameter int MASTER_WAIT = 10000,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          pwrOk,
  input  logic          m0In,
  input  logic [2:0]    modePins,
  input  seqCtl_t       ctl,
  input  logic          readyIn,
  output logic [AW-1:0] clrAddr,
  output logic [2:0]    modeOut,
  output logic          lastFrame,
  output logic          timerBusy,
  output logic          waitDone
);
  localparam int MASTER_DELAY = 4 * SLAVE_DELAY;
  localparam int TW = $clog2(MASTER_DELAY + 1);
  localparam int WW = (MASTER_WAIT > 1) ? $clog2(MASTER_WAIT + 1) : 1;

  logic [TW-1:0] timerCnt;
  logic [TW-1:0] timerLimit;
  logic [WW-1:0] waitCnt;

  assign timerLimit = m0In ? TW'(SLAVE_DELAY) : TW'(MASTER_DELAY);
  assign timerBusy  = timerCnt < timerLimit;
  assign lastFrame  = clrAddr == AW'(NUM_FRAMES - 1);
  assign waitDone   = waitCnt == WW'(MASTER_WAIT - 1);

  always_ff @(posedge clk) begin
    if (!pwrOk)         timerCnt <= '0;
    else if (timerBusy) timerCnt <= timerCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!pwrOk || ctl.addrZero) clrAddr <= '0;
    else if (ctl.clrRun)        clrAddr <= lastFrame ? '0 : clrAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!pwrOk || !ctl.waitRun) waitCnt <= '0;
    else                        waitCnt <= waitCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!pwrOk)            modeOut <= '0;
    else if (ctl.modeLoad) modeOut <= modePins;
  end

  // R3: address never leaves the frame range
  assert_addr_range_R3: assert property (@(posedge clk) disable iff (!pwrOk)
    clrAddr <= AW'(NUM_FRAMES - 1));

  // R12: captured mode is held while ready
  assert_mode_hold_R12: assert property (@(posedge clk) disable iff (!pwrOk)
    (readyIn && $past(readyIn)) |-> $stable(modeOut));
endmodule

// File: rtl/cfgseq_ctrl.sv
module cfgseq_ctrl
  import cfgseq_pkg::*;
(
  input  logic    clk,
  input  logic    pwrOk,
  input  logic    progReq,
  input  logic    initPinIn,
  input  logic    m0In,
  input  logic    lastFrame,
  input  logic    timerBusy,
  input  logic    waitDone,
  output seqCtl_t ctl,
  output logic    initLow,
  output logic    readyOut
);
  seqState_t state, nextState;

  always_ff @(posedge clk) begin
    if (!pwrOk) state <= ST_CLEAR;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    ctl = '0;
    case (state)
      ST_CLEAR: begin
        ctl.clrRun = 1'b1;
        if (lastFrame && !timerBusy && !progReq) nextState = ST_FINAL;
      end
      ST_FINAL: begin
        ctl.clrRun = 1'b1;
        if (progReq) begin
          nextState    = ST_CLEAR;
          ctl.addrZero = 1'b1;
        end else if (lastFrame) begin
          nextState = ST_WAIT_INIT;
        end
      end
      ST_WAIT_INIT: if (initPinIn) nextState = m0In ? ST_SYNC1 : ST_MDELAY;
      ST_MDELAY: begin
        ctl.waitRun = 1'b1;
        if (waitDone) nextState = ST_SYNC1;
      end
      ST_SYNC1: nextState = ST_SYNC2;
      ST_SYNC2: begin
        ctl.modeLoad = 1'b1;
        nextState    = ST_READY;
      end
      ST_READY: nextState = ST_READY;
      default:  nextState = ST_CLEAR;
    endcase
    if (progReq && !(state inside {ST_CLEAR, ST_FINAL})) begin
      nextState    = ST_CLEAR;
      ctl.waitRun  = 1'b0;
      ctl.modeLoad = 1'b0;
    end
  end

  assign initLow  = (state == ST_CLEAR) || (state == ST_FINAL);
  assign readyOut = state == ST_READY;

  // R6: the last pass only starts once timer and request were idle at a pass end
  assert_final_needs_idle_R6: assert property (@(posedge clk) disable iff (!pwrOk)
    (state == ST_FINAL && $past(state) == ST_CLEAR)
      |-> (!$past(progReq) && !$past(timerBusy) && $past(lastFrame)));

  // R8: a Low INIT pin keeps the block waiting
  assert_hold_while_init_low_R8: assert property (@(posedge clk) disable iff (!pwrOk)
    (state == ST_WAIT_INIT && !initPinIn && !progReq) |=> state == ST_WAIT_INIT);

  // R11: a late request always returns to clearing
  assert_prog_restart_R11: assert property (@(posedge clk) disable iff (!pwrOk)
    (progReq && !(state inside {ST_CLEAR, ST_FINAL})) |=> state == ST_CLEAR);
endmodule

// File: rtl/cfg_init_seq.sv
module cfg_init_seq
  import cfgseq_pkg::*;
#(
  parameter int NUM_FRAMES  = 256,
  parameter int SLAVE_DELAY = 1600000,
  parameter int MASTER_WAIT = 10000,
  localparam int AW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
  input  logic          clk,
  input  logic          pwrOk,
  input  logic          progReq,
  input  logic          initPinIn,
  input  logic          m0In,
  input  logic [2:0]    modePins,
  output logic [AW-1:0] clrAddr,
  output logic          clrStrobe,
  output logic          initDriveLow,
  output logic          ldcLevel,
  output logic          hdcLevel,
  output logic          doneLevel,
  output logic [2:0]    modeOut,
  output logic          ready
);
  seqCtl_t ctl;
  logic lastFrame, timerBusy, waitDone, initLow, readyInt;

  cfgseq_ctrl i_ctrl (
    .clk(clk), .pwrOk(pwrOk), .progReq(progReq), .initPinIn(initPinIn),
    .m0In(m0In), .lastFrame(lastFrame), .timerBusy(timerBusy),
    .waitDone(waitDone), .ctl(ctl), .initLow(initLow), .readyOut(readyInt)
  );

  cfgseq_dp #(
    .NUM_FRAMES(NUM_FRAMES), .SLAVE_DELAY(SLAVE_DELAY), .MASTER_WAIT(MASTER_WAIT)
  ) i_dp (
    .clk(clk), .pwrOk(pwrOk), .m0In(m0In), .modePins(modePins), .ctl(ctl),
    .readyIn(readyInt), .clrAddr(clrAddr), .modeOut(modeOut),
    .lastFrame(lastFrame), .timerBusy(timerBusy), .waitDone(waitDone)
  );

  assign clrStrobe    = ctl.clrRun & pwrOk;
  assign initDriveLow = initLow | ~pwrOk;
  assign ready        = readyInt & pwrOk;
  assign ldcLevel     = 1'b0;
  assign hdcLevel     = 1'b1;
  assign doneLevel    = 1'b0;
endmodule

// File: tb/test_cfg_init_seq.sv
module test_cfg_init_seq;
  localparam int N  = 8;
  localparam int SD = 40;
  localparam int MW = 20;
  localparam int AW = $clog2(N);

  logic clk = 1'b0;
  logic pwrOk = 1'b0, progReq = 1'b0, m0In = 1'b1, extHold = 1'b0;
  logic [2:0] modePins = 3'd0;
  logic initPinIn;
  logic [AW-1:0] clrAddr;
  logic clrStrobe, initDriveLow, ldcLevel, hdcLevel, doneLevel, ready;
  logic [2:0] modeOut;
  int nTests = 0, nFail = 0;

  always #5 clk = ~clk;
  // open-drain INIT wire with pull-up
  assign initPinIn = !initDriveLow && !extHold;

  cfg_init_seq #(.NUM_FRAMES(N), .SLAVE_DELAY(SD), .MASTER_WAIT(MW)) i_cfg_init_seq (
    .clk(clk), .pwrOk(pwrOk), .progReq(progReq), .initPinIn(initPinIn), .m0In(m0In),
    .modePins(modePins), .clrAddr(clrAddr), .clrStrobe(clrStrobe),
    .initDriveLow(initDriveLow), .ldcLevel(ldcLevel), .hdcLevel(hdcLevel),
    .doneLevel(doneLevel), .modeOut(modeOut), .ready(ready)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nTests++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    pwrOk = 1'b0; progReq = 1'b0; extHold = 1'b0;
    repeat (4) step();
    chk(initDriveLow == 1'b1, "R1 init driven", int'(initDriveLow), 1);
    chk(clrStrobe == 1'b0, "R1 strobe", int'(clrStrobe), 0);
    chk(ready == 1'b0, "R1 ready", int'(ready), 0);
    chk(ldcLevel == 1'b0 && doneLevel == 1'b0, "R2 ldc/done", int'({ldcLevel, doneLevel}), 0);
    chk(hdcLevel == 1'b1, "R2 hdc", int'(hdcLevel), 1);
  endtask

  // count strobes from the current sample until INIT is released
  task automatic count_clear(output int cnt, output int addrErr, output int lvlErr);
    cnt = 0; addrErr = 0; lvlErr = 0;
    for (int guard = 0; guard < 5000; guard++) begin
      if (!initDriveLow) break;
      if (clrStrobe) begin
        if (int'(clrAddr) != cnt % N) addrErr++;
        cnt++;
      end
      if (ldcLevel || doneLevel || !hdcLevel) lvlErr++;
      step();
    end
  endtask

  task automatic t_clear(input bit m0);
    int cnt, addrErr, lvlErr, lim, expCnt;
    m0In = m0;
    pwrOk = 1'b1;
    #1;
    count_clear(cnt, addrErr, lvlErr);
    lim = m0 ? SD : 4 * SD;
    expCnt = (((lim + 1) + N - 1) / N + 1) * N;
    chk(addrErr == 0, "R3 address sequence", addrErr, 0);
    chk(lvlErr == 0, "R2 levels during clear", lvlErr, 0);
    if (m0) chk(cnt == expCnt, "R4 slave strobe total", cnt, expCnt);
    else    chk(cnt == expCnt, "R5 master strobe total", cnt, expCnt);
  endtask

  // from a sample just after release: measure edges until ready
  task automatic t_wait_ready(input int expLat, input logic [2:0] newMode, input string req);
    int lat = 0;
    int relErr = 0;
    while (!ready && lat < 1000) begin
      step();
      lat++;
      if (initDriveLow) relErr++;
      if (lat == 1) modePins = newMode;
    end
    chk(relErr == 0, "R7 INIT stays released", relErr, 0);
    chk(lat == expLat, req, lat, expLat);
    chk(modeOut == newMode, "R9 latched mode", int'(modeOut), int'(newMode));
  endtask

  task automatic t_mode_hold();
    logic [2:0] held = modeOut;
    for (int k = 0; k < 10; k++) begin
      modePins = 3'(k);
      step();
      if (modeOut != held || !ready) begin
        chk(1'b0, "R12 mode held", int'(modeOut), int'(held));
        return;
      end
    end
    chk(1'b1, "R12 mode held", int'(modeOut), int'(held));
  endtask

  task automatic t_program(input bit hold, input int h);
    int cnt, addrErr, lvlErr, rest, expCnt;
    logic [2:0] prevMode = modeOut;
    extHold = hold;
    progReq = 1'b1;
    step();
    chk(initDriveLow == 1'b1 && ready == 1'b0, "R11 back to clear",
        int'({initDriveLow, ready}), 2);
    chk(clrAddr == '0 && clrStrobe == 1'b1, "R11 address restart", int'(clrAddr), 0);
    cnt = 0;
    for (int k = 0; k < h; k++) begin
      if (clrStrobe) cnt++;
      if (k == h - 1) progReq = 1'b0;
      else step();
    end
    step();
    count_clear(rest, addrErr, lvlErr);
    cnt += rest;
    expCnt = ((h + N - 1) / N) * N + N;
    chk(cnt == expCnt, "R6 one extra pass", cnt, expCnt);
    if (hold) begin
      int bad = 0;
      for (int k = 0; k < 40; k++) begin
        modePins = 3'(k);
        step();
        if (ready || modeOut != prevMode) bad++;
      end
      chk(bad == 0, "R8 no sampling while INIT low", bad, 0);
      extHold = 1'b0;
    end
  endtask

  initial begin
    t_reset();
    modePins = 3'd5;
    t_clear(1'b1);
    t_wait_ready(3, 3'd2, "R9 slave latency");
    t_mode_hold();
    t_program(1'b0, 20);
    t_wait_ready(3, 3'd6, "R9 slave latency after request");
    t_program(1'b1, 16);
    t_wait_ready(3, 3'd3, "R8 latency after outside release");
    t_reset();
    t_clear(1'b0);
    t_wait_ready(MW + 3, 3'd7, "R10 master latency");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nTests++;
    nFail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule